// File: doc/BRIEF.md
# Memory Byte Increment/Decrement Sequencer

This execution sub-unit of an 8-bit processor core adjusts one byte in memory in place. It receives a single start pulse with an opcode, a 16-bit pointer taken from a register pair, and the current flag bits. It then runs three machine cycles on a synchronous memory port. The first cycle reads the byte. The second computes the byte plus or minus one and the new flags. The third writes the result back to the same address.

The core decodes the opcode elsewhere and only forwards the two memory increment/decrement opcodes to this unit. The unit still protects itself. Any other opcode produces a one-cycle illegal pulse, and the unit goes straight back to idle without touching memory or the flags. The flags come back as a 4-bit vector ordered {zero, subtract, half-carry, carry} (bit 3 down to bit 0). The carry bit is always copied from the value supplied at start.

Top module: `mem_incdec_rmw`

## Requirements
- R1: Opcode 0x34 writes back the byte plus one and opcode 0x35 writes back the byte minus one, both modulo 256 (0xFF+1 = 0x00, 0x00-1 = 0xFF).
- R2: After an accepted legal start, the first cycle asserts `mem_rd` with no write, the second cycle asserts neither strobe, and the third asserts exactly one `mem_we` to the address that was read. Read data is expected on `mem_rdata` one cycle after `mem_rd`.
- R3: Result flag bit 3 (zero) is 1 exactly when the 8-bit result is 0x00.
- R4: Result flag bit 2 (subtract) is 1 for opcode 0x35 and 0 for opcode 0x34.
- R5: Result flag bit 1 (half-carry) is 1 on increment when the operand's low nibble is 0xF, and on decrement when the low nibble is 0x0 (so 0x10 becomes 0x0F with the bit set). Otherwise it is 0.
- R6: Result flag bit 0 (carry) equals bit 0 of `flags_in` as sampled at the accepted start.
- R7: The pointer is captured at the accepted start. Changes on `ptr` afterwards do not move the read or the write address.
- R8: A start with any other opcode raises `illegal` for exactly the next cycle, makes no memory access, leaves `flags_out` unchanged, and returns the unit to idle one cycle later.
- R9: `done` is high for exactly one cycle, the cycle that carries the write strobe. `ready` is high only while idle, and a start seen while not idle is ignored.
- R10: After reset, `ready` is 1 and `done`, `illegal`, `mem_rd` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, taken only while `ready` |
| opc | input | 8 | Opcode selecting the operation |
| ptr | input | 16 | Byte address from the register pair |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| ready | output | 1 | Unit is idle |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_rd` |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle unsupported-opcode pulse |
| flags_out | output | 4 | Updated flags {Z,N,H,C} |

## Verification
Call the clock edge that accepts a start E0. For a legal start, the read strobe and address appear in the cycle after E0. The cycle after that is quiet. The write strobe, write data, `done` and the new flags appear two cycles after the read, and the memory holds the new byte from the following cycle. For an illegal opcode, `illegal` appears in the cycle right after E0, and `ready` is back one cycle later.

The bench drives its inputs on falling edges and samples every output on the falling edge of the exact cycle given by this count. In that same cycle it changes `ptr` and `flags_in`, and it pokes `start` during busy cycles, to show that these changes have no effect.

// File: rtl/mem_incdec_pkg.sv
package mem_incdec_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_CALC  = 3'd2,
      ST_WRITE = 3'd3,
      ST_BAD   = 3'd4
   } rmw_state_e;

   localparam int FLAG_W = 4;
   localparam int FLG_Z  = 3;
   localparam int FLG_N  = 2;
   localparam int FLG_H  = 1;
   localparam int FLG_C  = 0;
endpackage

// File: rtl/mem_incdec_alu.sv
module mem_incdec_alu
   import mem_incdec_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] operand,
   input  logic              is_dec,
   input  logic              carry_in,
   output logic [DATA_W-1:0] result,
   output logic [FLAG_W-1:0] flags
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   initial begin
      if (DATA_W < 5) $error("mem_incdec_alu: DATA_W must exceed one nibble");
   end

   always_comb begin
      result = is_dec ? (operand - ONE) : (operand + ONE);
      flags[FLG_Z] = (result == '0);
      flags[FLG_N] = is_dec;
      flags[FLG_H] = is_dec ? (operand[3:0] == 4'h0) : (operand[3:0] == 4'hF);
      flags[FLG_C] = carry_in;
   end
endmodule

// File: rtl/mem_incdec_seq.sv
module mem_incdec_seq
   import mem_incdec_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       legal,
   output logic       accept,
   output rmw_state_e state
);
   rmw_state_e state_d;

   assign accept = start && (state == ST_IDLE);

   always_comb begin
      state_d = state;
      unique case (state)
         ST_IDLE:  if (start) state_d = legal ? ST_READ : ST_BAD;
         ST_READ:  state_d = ST_CALC;
         ST_CALC:  state_d = ST_WRITE;
         ST_WRITE: state_d = ST_IDLE;
         ST_BAD:   state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_d;
   end
endmodule

// File: rtl/mem_incdec_rmw.sv
module mem_incdec_rmw
   import mem_incdec_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 8,
   parameter int                OPC_W     = 8,
   parameter logic [OPC_W-1:0]  OPC_INC   = 8'h34,
   parameter logic [OPC_W-1:0]  OPC_DEC   = 8'h35,
   parameter bit                ADDR_HOLD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OPC_W-1:0]  opc,
   input  logic [ADDR_W-1:0] ptr,
   input  logic [FLAG_W-1:0] flags_in,
   output logic              ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic              illegal,
   output logic [FLAG_W-1:0] flags_out
);
   initial begin
      if (ADDR_W < 1)          $error("mem_incdec_rmw: ADDR_W must be positive");
      if (OPC_INC == OPC_DEC)  $error("mem_incdec_rmw: opcodes must differ");
   end

   rmw_state_e        state;
   logic              accept;
   logic              legal;
   logic              dec_sel;
   logic [ADDR_W-1:0] ptr_q;
   logic              dec_q;
   logic              carry_q;
   logic [DATA_W-1:0] res_q;
   logic [FLAG_W-1:0] flg_q;
   logic [DATA_W-1:0] alu_res;
   logic [FLAG_W-1:0] alu_flags;
   logic              in_access;

   assign legal   = (opc == OPC_INC) || (opc == OPC_DEC);
   assign dec_sel = (opc == OPC_DEC);

   mem_incdec_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .legal  (legal),
      .accept (accept),
      .state  (state)
   );

   mem_incdec_alu #(.DATA_W(DATA_W)) u_alu (
      .operand  (mem_rdata),
      .is_dec   (dec_q),
      .carry_in (carry_q),
      .result   (alu_res),
      .flags    (alu_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         dec_q   <= 1'b0;
         carry_q <= 1'b0;
         res_q   <= '0;
         flg_q   <= '0;
      end else begin
         if (accept && legal) begin
            ptr_q   <= ptr;
            dec_q   <= dec_sel;
            carry_q <= flags_in[FLG_C];
         end
         if (state == ST_CALC) begin
            res_q <= alu_res;
            flg_q <= alu_flags;
         end
      end
   end

   assign in_access = (state == ST_READ) || (state == ST_WRITE);

   generate
      if (ADDR_HOLD) begin : g_addr_hold
         assign mem_addr = ptr_q;
      end else begin : g_addr_gate
         assign mem_addr = in_access ? ptr_q : '0;
      end
   endgenerate

   assign ready     = (state == ST_IDLE);
   assign mem_rd    = (state == ST_READ);
   assign mem_we    = (state == ST_WRITE);
   assign mem_wdata = res_q;
   assign done      = (state == ST_WRITE);
   assign illegal   = (state == ST_BAD);
   assign flags_out = flg_q;
endmodule

// File: rtl/mem_incdec_rmw_chk.sv
module mem_incdec_rmw_chk #(
   parameter int               ADDR_W  = 16,
   parameter int               OPC_W   = 8,
   parameter logic [OPC_W-1:0] OPC_INC = 8'h34,
   parameter logic [OPC_W-1:0] OPC_DEC = 8'h35
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [OPC_W-1:0]  opc,
   input logic [3:0]        flags_in,
   input logic              ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_we,
   input logic              done,
   input logic              illegal,
   input logic [3:0]        flags_out
);
   logic go_legal;
   logic go_bad;
   assign go_legal = start && ready && ((opc == OPC_INC) || (opc == OPC_DEC));
   assign go_bad   = start && ready && !((opc == OPC_INC) || (opc == OPC_DEC));

   AST_READ_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n) go_legal |=> (mem_rd && !mem_we)); // R2
   AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |-> ##2 mem_we); // R2
   AST_WRITE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |-> ##2 (mem_addr == $past(mem_addr, 2))); // R7
   AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_we)); // R2
   AST_CARRY_PASS: assert property (@(posedge clk) disable iff (!rst_n) go_legal |-> ##3 (done && flags_out[0] == $past(flags_in[0], 3))); // R6
   AST_BAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) go_bad |=> (illegal && !mem_rd && !mem_we)); // R8
   AST_BAD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> $stable(flags_out)); // R8
   AST_BAD_BACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) illegal |=> (ready && !illegal)); // R8
   AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n) done |-> mem_we); // R9
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd || mem_we || illegal) |-> !ready); // R9
endmodule

bind mem_incdec_rmw mem_incdec_rmw_chk #(
   .ADDR_W (ADDR_W),
   .OPC_W  (OPC_W),
   .OPC_INC(OPC_INC),
   .OPC_DEC(OPC_DEC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .opc      (opc),
   .flags_in (flags_in),
   .ready    (ready),
   .mem_addr (mem_addr),
   .mem_rd   (mem_rd),
   .mem_we   (mem_we),
   .done     (done),
   .illegal  (illegal),
   .flags_out(flags_out)
);

// File: tb/mem_incdec_rmw_bench.sv
module mem_incdec_rmw_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opc = 8'h00;
   logic [15:0] ptr = 16'h0000;
   logic [3:0]  flags_in = 4'h0;
   logic        ready;
   logic [15:0] mem_addr;
   logic        mem_rd;
   logic        mem_we;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;
   logic        done;
   logic        illegal;
   logic [3:0]  flags_out;

   logic [7:0]  mem [0:255];
   logic        pl_en = 1'b0;
   logic [7:0]  pl_addr = 8'h00;
   logic [7:0]  pl_data = 8'h00;

   int vectors = 0;
   int errors  = 0;
   int cycles  = 0;

   always #2.5 clk = ~clk;

   mem_incdec_rmw u_mem_incdec_rmw (
      .clk(clk), .rst_n(rst_n), .start(start), .opc(opc), .ptr(ptr),
      .flags_in(flags_in), .ready(ready), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .done(done), .illegal(illegal), .flags_out(flags_out)
   );

   always_ff @(posedge clk) begin
      if (mem_we)     mem[mem_addr[7:0]] <= mem_wdata;
      else if (pl_en) mem[pl_addr] <= pl_data;
      if (mem_rd)     mem_rdata <= mem[mem_addr[7:0]];
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors = vectors + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_res(input logic dec, input logic [7:0] v);
      return dec ? v - 8'd1 : v + 8'd1;
   endfunction

   function automatic logic [3:0] exp_flags(input logic dec, input logic [7:0] v, input logic c);
      logic [7:0] r;
      r = exp_res(dec, v);
      return {r == 8'h00, dec, dec ? (v[3:0] == 4'h0) : (v[3:0] == 4'hF), c};
   endfunction

   task automatic preload(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      pl_en = 1'b1; pl_addr = a; pl_data = d;
      @(negedge clk);
      pl_en = 1'b0;
   endtask

   task automatic run_op(input logic [7:0] o, input logic [15:0] p, input logic [7:0] v,
                         input logic [3:0] f, input logic poke);
      logic       legal;
      logic       dec;
      logic [3:0] prev;
      legal = (o == 8'h34) || (o == 8'h35);
      dec   = (o == 8'h35);
      preload(p[7:0], v);
      prev = flags_out;
      start = 1'b1; opc = o; ptr = p; flags_in = f;
      @(negedge clk);
      start = 1'b0;
      ptr = ~p;
      flags_in = ~f;
      if (legal) begin
         check("R2 read cycle strobe", {mem_rd, mem_we, done}, 3'b100);
         check("R7 read address", mem_addr, p);
         if (poke) begin start = 1'b1; opc = 8'h00; end
         @(negedge clk);
         start = 1'b0;
         check("R2 quiet cycle", {mem_rd, mem_we}, 2'b00);
         check("R9 busy start ignored", {illegal, ready}, 2'b00);
         @(negedge clk);
         check("R9 done with write", {mem_we, done, ready, mem_rd}, 4'b1100);
         check("R7 write address", mem_addr, p);
         check("R1 write data", mem_wdata, exp_res(dec, v));
         check("R3 zero flag", flags_out[3], exp_flags(dec, v, f[0]) >> 3);
         check("R4 subtract flag", flags_out[2], dec);
         check("R5 half flag", flags_out[1], exp_flags(dec, v, f[0]) >> 1 & 1);
         check("R6 carry kept", flags_out[0], f[0]);
         @(negedge clk);
         check("R9 single done, idle", {done, mem_we, ready}, 3'b001);
         check("R1 memory updated", mem[p[7:0]], exp_res(dec, v));
      end else begin
         check("R8 illegal pulse no access", {illegal, mem_rd, mem_we, done}, 4'b1000);
         check("R8 flags untouched", flags_out, prev);
         @(negedge clk);
         check("R8 back to idle", {illegal, ready}, 2'b01);
         check("R8 memory untouched", mem[p[7:0]], v);
      end
   endtask

   initial begin
      void'($urandom(32'h1234_5678));
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      mem_rdata = 8'h00;
      repeat (3) @(negedge clk);
      check("R10 reset outputs", {ready, done, illegal, mem_rd, mem_we}, 5'b10000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 idle after reset", {ready, done, illegal, mem_rd, mem_we}, 5'b10000);
      // directed corners
      run_op(8'h35, 16'hC000, 8'h01, 4'b0000, 1'b0); // R3 R4 dec to zero
      run_op(8'h35, 16'hC011, 8'h10, 4'b0001, 1'b0); // R5 half-borrow
      run_op(8'h34, 16'hC022, 8'hFF, 4'b1110, 1'b1); // R1 wrap up, R5
      run_op(8'h35, 16'hC033, 8'h00, 4'b0001, 1'b0); // R1 wrap down
      run_op(8'h34, 16'hC044, 8'h0F, 4'b0000, 1'b0); // R5 nibble carry
      run_op(8'h34, 16'hC055, 8'h41, 4'b0001, 1'b1); // R6 R9
      run_op(8'h36, 16'hC066, 8'h77, 4'b1111, 1'b0); // R8
      run_op(8'h33, 16'hC077, 8'h12, 4'b0000, 1'b0); // R8
      for (int n = 0; n < 400; n++) begin
         logic [7:0] o;
         int sel;
         sel = $urandom_range(0, 9);
         o = (sel < 4) ? 8'h34 : (sel < 8) ? 8'h35 : 8'($urandom);
         run_op(o, 16'($urandom), 8'($urandom), 4'($urandom), 1'($urandom));
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule